// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block runs synchronous burst reads from a pseudo-static RAM or a NOR flash that samples its inputs on a clock edge. It divides the system clock into a memory clock with a programmable period. For each burst it pulls chip select and the address-valid strobe low together and presents the start word address. It then lets a programmed number of memory-clock cycles of latency pass. After that it captures one data word on each rising memory-clock edge and hands the word out with a one-cycle valid pulse in the system clock domain.

A request carries a start word address and a length in words. It is taken only when the block reports ready. When a page size is selected, a burst that would run past the end of a page is closed at the page's last word. The remaining words are then fetched in a new segment that starts at the first word of the next page, with its own address phase and latency. The memory clock either runs only while a burst is in flight or keeps toggling all the time, as set by an option input.

Top module: `sbm_burst_ctrl`

## Requirements
- R1: The memory clock period equals `cfg_period_i` system cycles, limited to the range 2 to 16 (below 2 gives 2, above 16 gives 16). The clock is high for the lower half of the period, that is floor(P/2) cycles.
- R2: With `cfg_cont_clk_i` low, `mem_clk_o` stays low while the block is idle. With it high, the memory clock toggles while idle as well. After reset `mem_clk_o` is low.
- R3: `mem_cs_no` and `mem_adv_no` go low together at a falling memory-clock edge, with the segment start address on `mem_addr_o`. The address stays stable while `mem_adv_no` is low, and `mem_adv_no` is low at exactly one rising memory-clock edge per segment.
- R4: With latency L, the first word of a segment is captured at the (L+1)-th rising memory-clock edge after the edge that latches the address. When `cfg_cram_i` is 1, `cfg_latency_i` is ignored and L is 0.
- R5: After the first word, one word is captured on each rising memory-clock edge from consecutive word addresses, which wrap at the address width. `rd_valid_o` is high for exactly one system cycle per word, and only while chip select is low.
- R6: `mem_cs_no` returns high at the first falling memory-clock edge after the last word, which is floor(P/2) system cycles after `rd_valid_o` for that word. `req_ready_o` is high again once the burst ends.
- R7: `cfg_page_i` selects the page size: 0 none, 1 is 128 bytes, 2 is 256, 3 is 512, 4 is 1024, and 5 to 7 none. A page holds bytes/(DW/8) words. A segment ends after the word whose address is the last in its page. Chip select then stays high for one memory-clock period, and a new segment starts at the next address.
- R8: A request with `req_len_i` equal to 0 is ignored: `req_ready_o` stays high, and neither chip select nor `rd_valid_o` becomes active.
- R9: A request is taken only in a cycle where `req_ready_o` is high. Requests raised during a burst have no effect on it.
- R10: `mem_cs_no` changes only at edges that leave `mem_clk_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_period_i | input | PW (5) | Memory clock period in system cycles |
| cfg_latency_i | input | LAT_W (5) | Memory-clock cycles before the first word |
| cfg_cram_i | input | 1 | Cellular RAM device: latency forced to 0 |
| cfg_page_i | input | 3 | Page size select |
| cfg_cont_clk_i | input | 1 | Keep the memory clock running while idle |
| req_valid_i | input | 1 | Burst request |
| req_addr_i | input | AW (16) | Start word address |
| req_len_i | input | LW (8) | Burst length in words |
| req_ready_o | output | 1 | Idle, request can be taken |
| mem_clk_o | output | 1 | Memory clock |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_adv_no | output | 1 | Address valid strobe, active low |
| mem_addr_o | output | AW (16) | Word address to memory |
| mem_data_i | input | DW (16) | Read data from memory |
| rd_data_o | output | DW (16) | Captured read word |
| rd_valid_o | output | 1 | One-cycle pulse per captured word |

## Verification
The hardest case to reach is a page split that lands in a long burst with a long latency and an odd clock period. Here the second segment has to repeat the address phase and the whole latency at the correct next address. The bench starts directed bursts one or two words below the boundary for several page sizes. It then mixes in seeded random start addresses, lengths, periods and latencies, so that splits, address wrap and clamped periods occur in many combinations. A memory model in the bench answers at the programmed latency, so a capture on the wrong edge shows up as a data mismatch.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_BURST,
    ST_END
  } sbm_state_e;

  localparam int PAGE_SEL_W = 3;
  localparam int PAGE_CODES = 5;
endpackage

// File: rtl/sbm_clk_gen.sv
module sbm_clk_gen #(
  parameter int CW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic [CW:0] period_i,
  output logic        mem_clk_o,
  output logic        rise_o,
  output logic        fall_o
);
  logic [CW-1:0] cnt_q, last, half_m1;
  logic          clk_q;

  assign last    = CW'(period_i - 1'b1);
  assign half_m1 = CW'((period_i >> 1) - 1'b1);
  assign rise_o  = en_i && (cnt_q >= last);
  assign fall_o  = en_i && !rise_o && (cnt_q == half_m1);
  assign mem_clk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= last;  // park so the first enabled edge rises at once
      clk_q <= 1'b0;
    end else if (rise_o) begin
      cnt_q <= '0;
      clk_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (fall_o) clk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sbm_page_det.sv
module sbm_page_det import sbm_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic [AW-1:0]         addr_i,
  input  logic [PAGE_SEL_W-1:0] page_sel_i,
  output logic                  page_last_o
);
  localparam int BLOG = $clog2(DW / 8);

  logic [AW-1:0] mask_tab [PAGE_CODES];
  logic [AW-1:0] mask;
  logic          en;

  assign mask_tab[0] = '0;
  for (genvar g = 1; g < PAGE_CODES; g++) begin : g_mask
    assign mask_tab[g] = AW'((1 << (6 + g - BLOG)) - 1);
  end

  always_comb begin
    en   = (page_sel_i != '0) && (page_sel_i < PAGE_SEL_W'(PAGE_CODES));
    mask = en ? mask_tab[page_sel_i] : '0;
  end

  assign page_last_o = en && ((addr_i & mask) == mask);
endmodule

// File: rtl/sbm_burst_fsm.sv
module sbm_burst_fsm import sbm_pkg::*; #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LW    = 8,
  parameter int LAT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [LW-1:0]    req_len_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             page_last_i,
  input  logic [DW-1:0]    mem_data_i,
  output logic             idle_o,
  output logic             cs_o,
  output logic             adv_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o
);
  sbm_state_e       state_q;
  logic [LW-1:0]    rem_q;
  logic [LAT_W-1:0] lat_q;

  assign idle_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      lat_q      <= '0;
      cs_o       <= 1'b0;
      adv_o      <= 1'b0;
      addr_o     <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i && req_len_i != '0) begin
          addr_o  <= req_addr_i;
          rem_q   <= req_len_i;
          state_q <= ST_START;
        end
        ST_START: if (fall_i) begin
          cs_o    <= 1'b1;
          adv_o   <= 1'b1;
          state_q <= ST_ADDR;
        end
        ST_ADDR: if (rise_i) begin
          lat_q   <= lat_i;
          state_q <= ST_BURST;
        end
        ST_BURST: begin
          if (fall_i) adv_o <= 1'b0;
          if (rise_i) begin
            if (lat_q != '0) begin
              lat_q <= lat_q - 1'b1;
            end else begin
              rd_data_o  <= mem_data_i;
              rd_valid_o <= 1'b1;
              addr_o     <= addr_o + 1'b1;
              rem_q      <= rem_q - 1'b1;
              if (rem_q == LW'(1) || page_last_i) state_q <= ST_END;
            end
          end
        end
        ST_END: if (fall_i) begin
          cs_o    <= 1'b0;
          state_q <= (rem_q != '0) ? ST_START : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbm_burst_ctrl.sv
module sbm_burst_ctrl import sbm_pkg::*; #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int LW      = 8,
  parameter int LAT_W   = 5,
  parameter int MAX_DIV = 16,
  localparam int CW     = $clog2(MAX_DIV),
  localparam int PW     = CW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PW-1:0]         cfg_period_i,
  input  logic [LAT_W-1:0]      cfg_latency_i,
  input  logic                  cfg_cram_i,
  input  logic [PAGE_SEL_W-1:0] cfg_page_i,
  input  logic                  cfg_cont_clk_i,
  input  logic                  req_valid_i,
  input  logic [AW-1:0]         req_addr_i,
  input  logic [LW-1:0]         req_len_i,
  output logic                  req_ready_o,
  output logic                  mem_clk_o,
  output logic                  mem_cs_no,
  output logic                  mem_adv_no,
  output logic [AW-1:0]         mem_addr_o,
  input  logic [DW-1:0]         mem_data_i,
  output logic [DW-1:0]         rd_data_o,
  output logic                  rd_valid_o
);
  logic [PW-1:0]    period_c;
  logic [LAT_W-1:0] lat_eff;
  logic             idle, clk_en, rise, fall, page_last, cs, adv;

  always_comb begin
    if (cfg_period_i < PW'(2))            period_c = PW'(2);
    else if (cfg_period_i > PW'(MAX_DIV)) period_c = PW'(MAX_DIV);
    else                                  period_c = cfg_period_i;
  end

  assign lat_eff = cfg_cram_i ? '0 : cfg_latency_i;
  assign clk_en  = cfg_cont_clk_i || !idle;

  sbm_clk_gen #(.CW(CW)) u_clk (
    .clk_i, .rst_ni, .en_i(clk_en), .period_i(period_c),
    .mem_clk_o, .rise_o(rise), .fall_o(fall)
  );

  sbm_page_det #(.AW(AW), .DW(DW)) u_page (
    .addr_i(mem_addr_o), .page_sel_i(cfg_page_i), .page_last_o(page_last)
  );

  sbm_burst_fsm #(.AW(AW), .DW(DW), .LW(LW), .LAT_W(LAT_W)) u_fsm (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall),
    .req_valid_i, .req_addr_i, .req_len_i, .lat_i(lat_eff),
    .page_last_i(page_last), .mem_data_i,
    .idle_o(idle), .cs_o(cs), .adv_o(adv), .addr_o(mem_addr_o),
    .rd_data_o, .rd_valid_o
  );

  assign req_ready_o = idle;
  assign mem_cs_no   = !cs;
  assign mem_adv_no  = !adv;
endmodule

// File: rtl/sbm_burst_ctrl_chk.sv
module sbm_burst_ctrl_chk #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_cont_clk_i,
  input logic          req_valid_i,
  input logic [LW-1:0] req_len_i,
  input logic          req_ready_o,
  input logic          mem_clk_o,
  input logic          mem_cs_no,
  input logic          mem_adv_no,
  input logic [AW-1:0] mem_addr_o,
  input logic          rd_valid_o
);
  a_r2_idle_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && $past(req_ready_o) && !cfg_cont_clk_i && !$past(cfg_cont_clk_i) |-> !mem_clk_o);

  a_r3_adv_with_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_adv_no) |-> $fell(mem_cs_no));

  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_no && !$past(mem_adv_no) |-> $stable(mem_addr_o));

  a_r5_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  a_r5_valid_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !mem_cs_no);

  a_r8_zero_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_len_i == '0 |=> req_ready_o);

  a_r10_cs_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_cs_no) |-> !mem_clk_o);
endmodule

bind sbm_burst_ctrl sbm_burst_ctrl_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_cont_clk_i(cfg_cont_clk_i),
  .req_valid_i(req_valid_i), .req_len_i(req_len_i), .req_ready_o(req_ready_o),
  .mem_clk_o(mem_clk_o), .mem_cs_no(mem_cs_no), .mem_adv_no(mem_adv_no),
  .mem_addr_o(mem_addr_o), .rd_valid_o(rd_valid_o)
);

// File: tb/sbm_burst_ctrl_test.sv
`timescale 1ns/1ps
module sbm_burst_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  cfg_period = 2, cfg_latency = 2;
  logic        cfg_cram = 0, cfg_cont = 0;
  logic [2:0]  cfg_page = 0;
  logic        req_valid = 0;
  logic [15:0] req_addr = 0;
  logic [7:0]  req_len = 0;
  logic        req_ready, mem_clk, mem_cs_n, mem_adv_n, rd_valid;
  logic [15:0] mem_addr, rd_data;
  logic [15:0] mem_data = 16'hDEAD;

  int n_chk = 0, n_err = 0;
  int cyc = 0, last_valid_cyc = 0, cs_rise_cyc = 0, cs_low_cnt = 0, r10_viol = 0;
  int lat_m = 0, mc = 0;
  logic [15:0] ma = 0;
  logic [15:0] got[$];
  logic [15:0] segs[$];
  logic prev_cs_n = 1, prev_mclk = 0;

  always #2.5 clk = ~clk;

  sbm_burst_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_period_i(cfg_period), .cfg_latency_i(cfg_latency),
    .cfg_cram_i(cfg_cram), .cfg_page_i(cfg_page), .cfg_cont_clk_i(cfg_cont),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_len_i(req_len), .req_ready_o(req_ready),
    .mem_clk_o(mem_clk), .mem_cs_no(mem_cs_n), .mem_adv_no(mem_adv_n), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  function automatic logic [15:0] word_of(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic int clamp_p(int p);
    return (p < 2) ? 2 : (p > 16) ? 16 : p;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: answers L+1 rising edges after the address edge
  always @(posedge mem_clk) begin
    if (!mem_cs_n && !mem_adv_n) begin
      ma = mem_addr; mc = 0; segs.push_back(mem_addr);
    end else if (!mem_cs_n) mc++;
    #1;
    if (!mem_cs_n && mc >= lat_m) mem_data = word_of(ma + 16'(mc - lat_m));
    else mem_data = 16'hDEAD;
  end

  always @(negedge clk) begin
    cyc++;
    if (rd_valid) begin got.push_back(rd_data); last_valid_cyc = cyc; end
    if (mem_cs_n && !prev_cs_n) cs_rise_cyc = cyc;
    if (mem_cs_n != prev_cs_n && mem_clk) r10_viol++;
    if (!mem_cs_n) cs_low_cnt++;
    prev_cs_n = mem_cs_n;
  end

  task automatic wait_idle();
    int guard = 0;
    while (!req_ready && guard < 20000) begin @(negedge clk); guard++; end
  endtask

  task automatic run_burst(logic [15:0] a, int len, int lat, bit cram, int page, int per,
                           bit cont, bit poke);
    logic [15:0] exp_segs[$];
    int pc, words;
    @(negedge clk);
    cfg_period = 5'(per); cfg_latency = 5'(lat); cfg_cram = cram;
    cfg_page = 3'(page); cfg_cont = cont;
    lat_m = cram ? 0 : lat;
    got.delete(); segs.delete();
    req_addr = a; req_len = 8'(len); req_valid = 1;
    @(negedge clk); req_valid = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_addr = a ^ 16'h1234; req_len = 8'd7; req_valid = 1;
      @(negedge clk); req_valid = 0;
    end
    wait_idle();
    repeat (4) @(negedge clk);
    pc = clamp_p(per);
    words = (page >= 1 && page <= 4) ? (64 << (page - 1)) : 0;
    exp_segs.push_back(a);
    for (int i = 1; i < len; i++) begin
      logic [15:0] ai = a + 16'(i);
      if (words != 0 && (ai & 16'(words - 1)) == 16'h0) exp_segs.push_back(ai);
    end
    check(got.size() == len, poke ? "R9 word count with busy request" : "R5 word count",
          got.size(), len);
    for (int i = 0; i < len && i < got.size(); i++)
      check(got[i] == word_of(a + 16'(i)), "R4 R5 data at latency", got[i], word_of(a + 16'(i)));
    check(segs.size() == exp_segs.size(), "R7 R3 segment count", segs.size(), exp_segs.size());
    for (int i = 0; i < exp_segs.size() && i < segs.size(); i++)
      check(segs[i] == exp_segs[i], "R7 R3 segment address", segs[i], exp_segs[i]);
    check(cs_rise_cyc - last_valid_cyc == pc / 2, "R6 cs release delay",
          cs_rise_cyc - last_valid_cyc, pc / 2);
    check(req_ready == 1'b1, "R6 ready after burst", req_ready, 1);
  endtask

  task automatic measure_period(int per);
    int hi = 0, lo = 0, guard = 0;
    @(negedge clk); cfg_cont = 1; cfg_period = 5'(per);
    repeat (40) @(negedge clk);
    while (!(mem_clk && !prev_mclk) && guard < 100) begin
      prev_mclk = mem_clk; @(negedge clk); guard++;
    end
    while (mem_clk && hi < 100) begin hi++; @(negedge clk); end
    while (!mem_clk && lo < 100) begin lo++; @(negedge clk); end
    prev_mclk = mem_clk;
    check(hi + lo == clamp_p(per), "R1 period", hi + lo, clamp_p(per));
    check(hi == clamp_p(per) / 2, "R1 high time", hi, clamp_p(per) / 2);
  endtask

  initial begin
    repeat (1900000) #0.1;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int hi_cnt, cs0, rdy_bad;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(mem_clk == 0, "R2 clock low in reset", mem_clk, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(req_ready == 1 && mem_cs_n == 1 && mem_adv_n == 1 && rd_valid == 0,
          "R9 reset state idle", {req_ready, mem_cs_n, mem_adv_n, rd_valid}, 4'b1110);

    // R2: gated clock in idle
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (mem_clk) hi_cnt++; end
    check(hi_cnt == 0, "R2 gated clock idle", hi_cnt, 0);

    // R1: periods including clamped settings
    measure_period(2);
    measure_period(3);
    measure_period(7);
    measure_period(16);
    measure_period(0);
    measure_period(25);
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (mem_clk) hi_cnt++; end
    check(hi_cnt > 0, "R2 continuous clock idle", hi_cnt, 1);
    @(negedge clk); cfg_cont = 0;
    repeat (4) @(negedge clk);

    // directed bursts
    run_burst(16'h0010, 4, 2, 0, 0, 2, 0, 0);
    run_burst(16'h003E, 5, 3, 0, 1, 4, 0, 0);
    run_burst(16'h01FF, 3, 17, 0, 4, 5, 1, 0);
    run_burst(16'h00FE, 4, 9, 1, 2, 3, 0, 0);
    run_burst(16'hFFFE, 4, 2, 0, 0, 16, 0, 0);
    run_burst(16'h007F, 2, 2, 0, 6, 2, 0, 0);
    run_burst(16'h00FF, 3, 0, 0, 3, 3, 0, 0);
    run_burst(16'h0100, 6, 4, 0, 0, 3, 0, 1);

    // R8: zero length
    @(negedge clk); cfg_cont = 0;
    got.delete(); cs0 = cs_low_cnt; rdy_bad = 0;
    req_addr = 16'h0040; req_len = 0; req_valid = 1;
    @(negedge clk); req_valid = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!req_ready) rdy_bad++; end
    check(rdy_bad == 0, "R8 ready stays high", rdy_bad, 0);
    check(cs_low_cnt == cs0, "R8 no chip select", cs_low_cnt - cs0, 0);
    check(got.size() == 0, "R8 no data", got.size(), 0);

    // random mix
    for (int k = 0; k < 30; k++) begin
      run_burst(16'($urandom), 1 + int'($urandom_range(39)), int'($urandom_range(17)),
                1'($urandom_range(1)), int'($urandom_range(7)), int'($urandom_range(20)),
                1'($urandom_range(1)), 1'($urandom_range(1)));
    end

    check(r10_viol == 0, "R10 chip select moves with clock low", r10_viol, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule